// File: doc/BRIEF.md
# Two-Channel Interrupt Vector Unit

This block gathers the interrupt requests of a two-channel serial controller and turns them into one request line and an 8-bit vector. Each channel, called A and B, raises four kinds of event: a received character, a special receive condition, an empty transmit buffer and a change of external status. Per-channel enable bits decide which events become pending. The pending bits of both channels can be read together in one status byte.

Six priority levels are ranked, with channel A above channel B. The receive level is shared by ordinary received characters and special receive conditions. When the CPU acknowledges the request, the winning level moves from pending to in-service. While a level is in service, it masks itself and every level below it. A reset-highest-in-service command written to the command register ends the service of the top in-service level.

The vector is a programmable base byte. A 3-bit status code that names the channel and the cause can be merged into it, either in bits 3:1 or in bits 6:4. Vector output can also be turned off.

Top module: `sio_irq_vector`

## Requirements
- R1: After reset, `irq` and `vec_en` are 0, `rr3` is 0x00, and all control registers and in-service bits are clear.
- R2: `rr3` shows the pending bits at these positions: bit0 B external/status, bit1 B transmit, bit2 B receive, bit3 A external/status, bit4 A transmit, bit5 A receive. Bits 7:6 read 0.
- R3: The event buses are bit0 external/status, bit1 transmit empty, bit2 receive character, bit3 special receive. Register 1 of a channel is written with `wr_reg`=1 and `wr_chan_a` selecting the channel (1 means A). In that register, bit0 lets external/status events set pending and bit1 lets transmit events set pending. A disabled event is ignored.
- R4: Register 1 bits 4:3 select the receive mode. With 00, no receive event sets pending. With 01, only the first character after a write to that register sets pending, and every special condition does too. With 10, every character and every special condition sets pending. With 11, only special conditions set pending.
- R5: Register 9 (`wr_reg`=9, shared by both channels) bit3 is the master enable. `irq` is 1 only when the master enable is set and some pending level is strictly above every level in service.
- R6: The priority from highest to lowest is A receive, A transmit, A external, B receive, B transmit, B external. The vector always describes the highest pending level that is not masked.
- R7: Status codes are: B transmit 0, B external 1, B receive 2, B special 3, A transmit 4, A external 5, A receive 6, A special 7. The vector base is written to register 2. When register 9 bit0 is 0, the vector is the base unchanged. When bit0 is 1 and bit4 is 0, the code replaces base bits 3:1. When bit0 is 1 and bit4 is 1, the code replaces base bits 6:4.
- R8: When register 9 bit1 is set (no vector), `vec_en` stays 0 while `irq` behaves as usual.
- R9: An `iack` pulse while `irq` is 1 moves the winning level from pending to in-service in the next cycle and clears its special flag.
- R10: Writing register 0 with bits 5:3 equal to 111 (command 0x38) clears the highest set in-service bit, and only that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_chan_a | input | 1 | Channel select for register 1: 1 selects A, 0 selects B |
| wr_reg | input | 4 | Register number (0 = command, 1 = channel enables, 2 = vector base, 9 = master control) |
| wr_data | input | 8 | Write data |
| ch_a_ev | input | 4 | Channel A event strobes (external, transmit, receive, special) |
| ch_b_ev | input | 4 | Channel B event strobes |
| iack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| vec | output | 8 | Vector for the current winning level |
| vec_en | output | 1 | The vector should be placed on the bus |
| rr3 | output | 8 | Pending bits of both channels |

## Verification
If the in-service state is wrong, it shows within one cycle of an acknowledge or of a reset-in-service command. Either `irq` stays low while a higher level is still pending, or `irq` rises again too early and names a level whose vector code is below the level that should be in service. If a pending bit is wrong, it appears in `rr3` on the cycle after the event that set it. If a special flag is left set, the next receive vector of that channel carries the odd code, so the bench acknowledges each level in turn and checks every code the vector produces.

// File: rtl/sio_irq_vector.sv
module sio_irq_vector (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_chan_a,
  input  logic [3:0] wr_reg,
  input  logic [7:0] wr_data,
  input  logic [3:0] ch_a_ev,
  input  logic [3:0] ch_b_ev,
  input  logic       iack,
  output logic       irq,
  output logic [7:0] vec,
  output logic       vec_en,
  output logic [7:0] rr3
);
  localparam int NLVL = 6;

  logic [7:0] ctl_a, ctl_b, vbase, mctl;
  logic [NLVL-1:0] pend, ius;
  logic [1:0] spec, armed;

  wire mie  = mctl[3];
  wire vis  = mctl[0];
  wire nv   = mctl[1];
  wire sthi = mctl[4];
  wire [1:0] md_a = ctl_a[4:3];
  wire [1:0] md_b = ctl_b[4:3];

  wire wr1_a  = wr_en && wr_reg == 4'd1 && wr_chan_a;
  wire wr1_b  = wr_en && wr_reg == 4'd1 && !wr_chan_a;
  wire rstcmd = wr_en && wr_reg == 4'd0 && wr_data[5:3] == 3'b111;

  wire chr_a = ch_a_ev[2] && (md_a == 2'b10 || (md_a == 2'b01 && armed[1]));
  wire chr_b = ch_b_ev[2] && (md_b == 2'b10 || (md_b == 2'b01 && armed[0]));
  wire sp_a  = ch_a_ev[3] && md_a != 2'b00;
  wire sp_b  = ch_b_ev[3] && md_b != 2'b00;

  wire [NLVL-1:0] setv = {chr_a | sp_a, ch_a_ev[1] & ctl_a[1], ch_a_ev[0] & ctl_a[0],
                          chr_b | sp_b, ch_b_ev[1] & ctl_b[1], ch_b_ev[0] & ctl_b[0]};

  logic [NLVL-1:0] blocked, allowed, win_oh, ius_top;
  logic [2:0] win;
  logic hit;

  always_comb begin
    blocked = '0;
    for (int i = 0; i < NLVL; i++) blocked[i] = |(ius >> i);
    allowed = pend & ~blocked;
    win = '0;
    hit = 1'b0;
    for (int i = NLVL - 1; i >= 0; i--)
      if (!hit && allowed[i]) begin
        win = 3'(i);
        hit = 1'b1;
      end
    win_oh = hit ? (NLVL'(1) << win) : '0;
    ius_top = '0;
    for (int i = 0; i < NLVL; i++)
      if (ius[i]) ius_top = NLVL'(1) << i;
  end

  logic chan;
  logic [1:0] kind;
  logic [2:0] code;

  always_comb begin
    chan = win >= 3'd3;
    case (chan ? win - 3'd3 : win)
      3'd0:    kind = 2'b01;
      3'd1:    kind = 2'b00;
      default: kind = {1'b1, chan ? spec[1] : spec[0]};
    endcase
    code = {chan, kind};
  end

  assign irq    = mie && hit;
  assign vec_en = irq && !nv;
  assign vec    = !vis ? vbase
                : sthi ? {vbase[7], code, vbase[3:0]}
                       : {vbase[7:4], code, vbase[0]};
  assign rr3    = {2'b00, pend};

  wire take = iack && irq;
  wire [NLVL-1:0] clr = take ? win_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_a <= '0;
      ctl_b <= '0;
      vbase <= '0;
      mctl  <= '0;
      pend  <= '0;
      ius   <= '0;
      spec  <= '0;
      armed <= 2'b11;
    end else begin
      if (wr1_a) ctl_a <= wr_data;
      if (wr1_b) ctl_b <= wr_data;
      if (wr_en && wr_reg == 4'd2) vbase <= wr_data;
      if (wr_en && wr_reg == 4'd9) mctl <= wr_data;
      pend <= (pend & ~clr) | setv;
      ius  <= (ius & ~(rstcmd ? ius_top : '0)) | clr;
      spec[1] <= (spec[1] && !clr[5]) || sp_a;
      spec[0] <= (spec[0] && !clr[2]) || sp_b;
      armed[1] <= wr1_a || (armed[1] && !(chr_a && md_a == 2'b01));
      armed[0] <= wr1_b || (armed[0] && !(chr_b && md_b == 2'b01));
    end
  end
endmodule

module sio_irq_vector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       vec_en,
  input logic       iack,
  input logic [7:0] rr3,
  input logic [7:0] mctl,
  input logic [5:0] ius,
  input logic       rstcmd,
  input logic [3:0] ch_a_ev,
  input logic [3:0] ch_b_ev
);
  // R5
  no_irq_without_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mctl[3] |-> !irq);
  // R5
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rr3[5:0] != 6'd0);
  // R8
  no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mctl[1] |-> !vec_en);
  // R9
  ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack && irq && !rstcmd |=> $countones(ius) == $countones($past(ius)) + 1);
  // R10
  reset_one_ius_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rstcmd && !(iack && irq) && ius != 6'd0 |=> $countones(ius) == $countones($past(ius)) - 1);
  // R2
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_a_ev == 4'd0 && ch_b_ev == 4'd0 && !iack |=> rr3 == $past(rr3));
endmodule

bind sio_irq_vector sio_irq_vector_chk i_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .vec_en(vec_en), .iack(iack), .rr3(rr3),
  .mctl(mctl), .ius(ius), .rstcmd(rstcmd), .ch_a_ev(ch_a_ev), .ch_b_ev(ch_b_ev)
);

// File: tb/test_sio_irq_vector.sv
module test_sio_irq_vector;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_chan_a = 1'b0, iack = 1'b0;
  logic [3:0] wr_reg = '0, ch_a_ev = '0, ch_b_ev = '0;
  logic [7:0] wr_data = '0;
  logic irq, vec_en;
  logic [7:0] vec, rr3;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_irq_vector i_sio_irq_vector (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wreg(input logic cha, input logic [3:0] r, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_chan_a = cha; wr_reg = r; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ev(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk); ch_a_ev = a; ch_b_ev = b;
    @(negedge clk); ch_a_ev = '0; ch_b_ev = '0;
  endtask

  task automatic ack();
    @(negedge clk); iack = 1'b1;
    @(negedge clk); iack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq", irq, 0); chk("R1 vec_en", vec_en, 0);
    chk("R1 rr3", rr3, 8'h00); chk("R1 vec", vec, 8'h00);
  endtask

  task automatic t_rr3_map();
    do_reset();
    wreg(1, 1, 8'h13); wreg(0, 1, 8'h13);
    ev(4'b0001, 4'b0000); chk("R2 A ext bit3", rr3, 8'h08);
    ev(4'b0010, 4'b0000); chk("R2 A tx bit4", rr3, 8'h18);
    ev(4'b0100, 4'b0000); chk("R2 A rx bit5", rr3, 8'h38);
    ev(4'b0000, 4'b0001); chk("R2 B ext bit0", rr3, 8'h39);
    ev(4'b0000, 4'b0010); chk("R2 B tx bit1", rr3, 8'h3B);
    ev(4'b0000, 4'b1000); chk("R2 B special bit2", rr3, 8'h3F);
    chk("R5 no irq with master off", irq, 0);
  endtask

  task automatic t_enables();
    do_reset();
    wreg(1, 1, 8'h10); wreg(0, 1, 8'h01);
    ev(4'b0011, 4'b0010); chk("R3 disabled ext/tx ignored", rr3, 8'h00);
    ev(4'b0000, 4'b0001); chk("R3 B ext enabled", rr3, 8'h01);
  endtask

  task automatic t_rx_modes();
    do_reset();
    wreg(1, 1, 8'h03);
    ev(4'b1100, 4'b0000); chk("R4 mode 00 ignores rx", rr3, 8'h00);
    wreg(1, 1, 8'h0B); wreg(0, 9, 8'h08);
    ev(4'b0100, 4'b0000); chk("R4 mode 01 first char", rr3, 8'h20);
    ack(); chk("R9 ack clears pending", rr3, 8'h00);
    wreg(0, 0, 8'h38);
    ev(4'b0100, 4'b0000); chk("R4 mode 01 second char ignored", rr3, 8'h00);
    ev(4'b1000, 4'b0000); chk("R4 mode 01 special", rr3, 8'h20);
    ack(); wreg(0, 0, 8'h38);
    wreg(1, 1, 8'h1B);
    ev(4'b0100, 4'b0000); chk("R4 mode 11 char ignored", rr3, 8'h00);
    ev(4'b1000, 4'b0000); chk("R4 mode 11 special", rr3, 8'h20);
  endtask

  task automatic t_priority();
    logic [7:0] exp_v[6] = '{8'hAD, 8'hA9, 8'hAB, 8'hA5, 8'hA1, 8'hA3};
    do_reset();
    wreg(1, 1, 8'h13); wreg(0, 1, 8'h13); wreg(0, 2, 8'hA1); wreg(0, 9, 8'h09);
    ev(4'b0111, 4'b0111);
    for (int k = 0; k < 6; k++) begin
      chk("R6 irq for next level", irq, 1);
      chk("R7 R6 vector code", vec, exp_v[k]);
      chk("R8 vec_en", vec_en, 1);
      ack();
      chk("R9 in service masks lower", irq, 0);
      wreg(0, 0, 8'h38);
    end
    chk("R9 all served", rr3, 8'h00);
  endtask

  task automatic t_nesting();
    do_reset();
    wreg(1, 1, 8'h13); wreg(0, 1, 8'h13); wreg(0, 2, 8'h00); wreg(0, 9, 8'h09);
    ev(4'b0000, 4'b0010); ack();
    ev(4'b0100, 4'b0000);
    chk("R5 higher level nests", irq, 1); chk("R7 A rx code", vec, 8'h0C);
    ack();
    ev(4'b0000, 4'b0001);
    chk("R5 lower level masked", irq, 0);
    wreg(0, 0, 8'h38);
    chk("R10 only top IUS cleared", irq, 0);
    wreg(0, 0, 8'h38);
    chk("R10 second reset unmasks", irq, 1); chk("R7 B ext code", vec, 8'h02);
  endtask

  task automatic t_vector_modes();
    do_reset();
    wreg(1, 1, 8'h13); wreg(0, 2, 8'h81); wreg(0, 9, 8'h19);
    ev(4'b1000, 4'b0000);
    chk("R7 A special high placement", vec, 8'hF1);
    wreg(0, 9, 8'h08); chk("R7 no status base only", vec, 8'h81);
    wreg(0, 9, 8'h0B);
    chk("R8 no vector", vec_en, 0); chk("R8 irq still up", irq, 1);
    wreg(0, 9, 8'h01); chk("R5 master off", irq, 0);
  endtask

  initial begin
    t_reset(); t_rr3_map(); t_enables(); t_rx_modes();
    t_priority(); t_nesting(); t_vector_modes();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule